// File: doc/BRIEF.md
# Processor debug mode entry controller

This block decides when a processor core drops into debug mode, why it did so, and how it gets back out. Each cycle it looks at a vector of debug event requests, a forced request from an external development port, and a request sampled as reset is released. Software chooses which events may cause entry by writing an enable register. The reason for each entry is kept in a cause register, which software reads and clears while the core is halted.

On entry the block stores the program counter of the interrupted instruction and the privilege level the core was running at. It then forces supervisor privilege and points instruction fetch at the development port. Loads and stores keep going to system memory. When a resume command arrives, the block hands the saved address to the core as a one-cycle program-counter load and restores the saved privilege level. The block also drives a status bit that is the OR of all cause bits. This bit stays live during debug mode, so the port can see events that arrive after entry.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: An event request whose enable bit is 0 does not change debug_active and does not set its cause bit.
- R2: While debug_active is 0, an event request whose enable bit is 1, with irq_en at 1, sets debug_active from the next cycle. It also sets cause bit i for event i (cause bits 0..NUM_EVT-1 map to the event inputs).
- R3: When several enabled events are requested in the same cycle, all of their cause bits are set in the next cycle and the block enters debug mode once. A later single resume leaves debug mode.
- R4: force_req sets debug_active from the next cycle even when irq_en is 0, and it sets cause bit NUM_EVT. An enabled event with irq_en at 0 sets its cause bit but does not enter debug mode.
- R5: If reset_dbg_req is 1 in the first cycle after rst_n is released, debug_active is 1 after that cycle's clock edge and cause bit NUM_EVT+1 is set.
- R6: From the cycle after entry, priv_user is 0 (supervisor) and fetch_src_port is 1 (fetch from the development port).
- R7: A resume while debug_active is 1 gives, in the next cycle, debug_active 0, fetch_src_port 0, and a one-cycle pc_load_valid pulse. In that cycle pc_load_addr equals the cur_pc sampled at entry, and priv_user equals the cur_priv sampled at entry.
- R8: A write with sw_we=1 and sw_sel=1 clears each cause bit where sw_wdata is 1 and leaves the other bits unchanged. A cause bit that is being set in the same cycle stays set.
- R9: cause_any is 1 exactly when any cause bit is 1. An enabled event that arrives while debug_active is 1 sets its cause bit without leaving debug mode.
- R10: After reset, debug_active, fetch_src_port, priv_user, pc_load_valid, enable_q and cause_q are all 0.
- R11: A write with sw_we=1 and sw_sel=0 loads enable_q from the low NUM_EVT bits of sw_wdata, starting in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_req | input | NUM_EVT | Debug event requests, one bit per event type |
| irq_en | input | 1 | Core interrupt enable; gates entry on events |
| force_req | input | 1 | Forced entry from the development port |
| reset_dbg_req | input | 1 | Request to enter debug mode straight out of reset |
| resume | input | 1 | Leave debug mode |
| cur_pc | input | PC_W | Address of the instruction being interrupted |
| cur_priv | input | 1 | Current privilege of the core, 1 = user |
| sw_we | input | 1 | Register write strobe |
| sw_sel | input | 1 | Register select, 0 = enable, 1 = cause (write one to clear) |
| sw_wdata | input | NUM_EVT+2 | Register write data |
| enable_q | output | NUM_EVT | Enable register contents |
| cause_q | output | NUM_EVT+2 | Cause register contents |
| cause_any | output | 1 | OR of all cause bits |
| debug_active | output | 1 | Core is in debug mode |
| fetch_src_port | output | 1 | 1 = fetch from the development port, 0 = from memory |
| priv_user | output | 1 | Privilege override, 0 = supervisor |
| pc_load_valid | output | 1 | One-cycle pulse that loads the program counter |
| pc_load_addr | output | PC_W | Restart address for the core |

## Verification
Most internal faults show up on the ports within one or two cycles, because each one is tied to a specific output.

| Internal fault | What the ports show |
|---|---|
| Stuck mode state | debug_active and fetch_src_port are wrong in the cycle after the triggering request. |
| Wrong enable or cause mask | An unexpected cause_q pattern and cause_any appear in the same cycle, or an entry is missing. |
| Corrupted saved address or privilege | Wrong values appear only when pc_load_valid pulses, one cycle after resume. |

The scenarios therefore always end with a resume, so that the saved state is exposed at the ports.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic {MODE_RUN = 1'b0, MODE_DEBUG = 1'b1} dbg_mode_e;

  // Cause-word update: new sets win over write-one-to-clear.
  function automatic logic [63:0] cause_next(input logic [63:0] cur,
                                             input logic [63:0] set,
                                             input logic [63:0] clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/dbg_evt_mask.sv
module dbg_evt_mask #(
  parameter int NUM_EVT = 8
) (
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic [NUM_EVT-1:0] enable_q,
  input  logic               irq_en,
  output logic [NUM_EVT-1:0] evt_hit,
  output logic               evt_entry
);
  assign evt_hit   = evt_req & enable_q;
  assign evt_entry = (|evt_hit) & irq_en;
endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] set_vec,
  input  logic [CW-1:0] clr_vec,
  output logic [CW-1:0] cause_q
);
  import dbg_pkg::*;
  logic [63:0] nxt;
  assign nxt = cause_next(64'(cause_q), 64'(set_vec), 64'(clr_vec));

  for (genvar i = 0; i < CW; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[i] <= 1'b0;
      else        cause_q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_fire,
  input  logic            resume_fire,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            cur_priv,
  output logic            debug_active,
  output logic            priv_user,
  output logic            pc_load_valid,
  output logic [PC_W-1:0] pc_load_addr,
  output logic [PC_W-1:0] saved_pc,
  output logic            saved_priv
);
  import dbg_pkg::*;
  dbg_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= MODE_RUN;
      priv_user     <= 1'b0;
      pc_load_valid <= 1'b0;
      pc_load_addr  <= '0;
      saved_pc      <= '0;
      saved_priv    <= 1'b0;
    end else begin
      pc_load_valid <= 1'b0;
      if (resume_fire) begin
        mode_q        <= MODE_RUN;
        priv_user     <= saved_priv;
        pc_load_valid <= 1'b1;
        pc_load_addr  <= saved_pc;
      end else if (entry_fire) begin
        mode_q     <= MODE_DEBUG;
        priv_user  <= 1'b0;
        saved_pc   <= cur_pc;
        saved_priv <= cur_priv;
      end
    end
  end

  assign debug_active = (mode_q == MODE_DEBUG);
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int NUM_EVT = 8,
  parameter int PC_W    = 32,
  localparam int CW     = NUM_EVT + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic               irq_en,
  input  logic               force_req,
  input  logic               reset_dbg_req,
  input  logic               resume,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic               cur_priv,
  input  logic               sw_we,
  input  logic               sw_sel,
  input  logic [CW-1:0]      sw_wdata,
  output logic [NUM_EVT-1:0] enable_q,
  output logic [CW-1:0]      cause_q,
  output logic               cause_any,
  output logic               debug_active,
  output logic               fetch_src_port,
  output logic               priv_user,
  output logic               pc_load_valid,
  output logic [PC_W-1:0]    pc_load_addr
);
  logic               boot_q;
  logic               boot_entry;
  logic [NUM_EVT-1:0] evt_hit;
  logic               evt_entry;
  logic               entry_fire;
  logic               resume_fire;
  logic [CW-1:0]      set_vec;
  logic [CW-1:0]      clr_vec;
  logic [PC_W-1:0]    saved_pc;
  logic               saved_priv;

  // First-cycle-after-reset marker for entry straight out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end
  assign boot_entry = boot_q & reset_dbg_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 enable_q <= '0;
    else if (sw_we && !sw_sel)  enable_q <= sw_wdata[NUM_EVT-1:0];
  end

  dbg_evt_mask #(.NUM_EVT(NUM_EVT)) u_mask (
    .evt_req  (evt_req),
    .enable_q (enable_q),
    .irq_en   (irq_en),
    .evt_hit  (evt_hit),
    .evt_entry(evt_entry)
  );

  assign entry_fire  = !debug_active && (evt_entry || force_req || boot_entry);
  assign resume_fire = debug_active && resume;

  assign set_vec = {boot_entry, force_req, evt_hit};
  assign clr_vec = (sw_we && sw_sel) ? sw_wdata : '0;

  dbg_cause_reg #(.CW(CW)) u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .cause_q(cause_q)
  );
  assign cause_any = |cause_q;

  dbg_mode_fsm #(.PC_W(PC_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .entry_fire   (entry_fire),
    .resume_fire  (resume_fire),
    .cur_pc       (cur_pc),
    .cur_priv     (cur_priv),
    .debug_active (debug_active),
    .priv_user    (priv_user),
    .pc_load_valid(pc_load_valid),
    .pc_load_addr (pc_load_addr),
    .saved_pc     (saved_pc),
    .saved_priv   (saved_priv)
  );

  assign fetch_src_port = debug_active;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int NUM_EVT = 8,
  parameter int PC_W    = 32,
  localparam int CW     = NUM_EVT + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_req,
  input logic [NUM_EVT-1:0] enable_q,
  input logic               irq_en,
  input logic               force_req,
  input logic               resume,
  input logic               sw_we,
  input logic               sw_sel,
  input logic [CW-1:0]      cause_q,
  input logic               debug_active,
  input logic               priv_user,
  input logic               pc_load_valid,
  input logic [PC_W-1:0]    pc_load_addr,
  input logic [PC_W-1:0]    saved_pc
);
  assert_evt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!debug_active && irq_en && |(evt_req & enable_q)) |=> debug_active);

  assert_force_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!debug_active && force_req) |=> debug_active);

  assert_masked_no_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!debug_active && !force_req && !(irq_en && |(evt_req & enable_q)) && !$past(!rst_n))
      |=> !$rose(debug_active));

  assert_supervisor_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(debug_active) |-> !priv_user);

  assert_resume_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_active && resume) |=> (!debug_active && pc_load_valid && pc_load_addr == $past(saved_pc)));

  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_we && sw_sel) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_stay_debug_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_active && !resume) |=> debug_active);
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.NUM_EVT(NUM_EVT), .PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_req      (evt_req),
  .enable_q     (enable_q),
  .irq_en       (irq_en),
  .force_req    (force_req),
  .resume       (resume),
  .sw_we        (sw_we),
  .sw_sel       (sw_sel),
  .cause_q      (cause_q),
  .debug_active (debug_active),
  .priv_user    (priv_user),
  .pc_load_valid(pc_load_valid),
  .pc_load_addr (pc_load_addr),
  .saved_pc     (saved_pc)
);

// File: tb/tb_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_entry_ctrl;
  localparam int NUM_EVT = 8;
  localparam int PC_W    = 32;
  localparam int CW      = NUM_EVT + 2;
  localparam int FORCE_BIT = NUM_EVT;
  localparam int BOOT_BIT  = NUM_EVT + 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_EVT-1:0] evt_req;
  logic               irq_en, force_req, reset_dbg_req, resume, cur_priv;
  logic [PC_W-1:0]    cur_pc;
  logic               sw_we, sw_sel;
  logic [CW-1:0]      sw_wdata;
  logic [NUM_EVT-1:0] enable_q;
  logic [CW-1:0]      cause_q;
  logic               cause_any, debug_active, fetch_src_port, priv_user, pc_load_valid;
  logic [PC_W-1:0]    pc_load_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dbg_entry_ctrl #(.NUM_EVT(NUM_EVT), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .irq_en(irq_en),
    .force_req(force_req), .reset_dbg_req(reset_dbg_req), .resume(resume),
    .cur_pc(cur_pc), .cur_priv(cur_priv), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .enable_q(enable_q), .cause_q(cause_q),
    .cause_any(cause_any), .debug_active(debug_active),
    .fetch_src_port(fetch_src_port), .priv_user(priv_user),
    .pc_load_valid(pc_load_valid), .pc_load_addr(pc_load_addr)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change at negedge; one posedge later the registered result is sampled.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    evt_req = '0; force_req = 0; resume = 0; sw_we = 0; sw_sel = 0; sw_wdata = '0;
  endtask

  task automatic do_reset(logic boot_req);
    idle_inputs();
    irq_en = 1; cur_pc = '0; cur_priv = 1; reset_dbg_req = boot_req;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic sw_write(logic sel, logic [CW-1:0] d);
    sw_we = 1; sw_sel = sel; sw_wdata = d;
    step();
    sw_we = 0; sw_wdata = '0;
  endtask

  task automatic do_resume();
    resume = 1;
    step();
    resume = 0;
  endtask

  task automatic t_reset_state();
    check("R10 debug_active", 64'(debug_active), 0);
    check("R10 fetch_src_port", 64'(fetch_src_port), 0);
    check("R10 priv_user", 64'(priv_user), 0);
    check("R10 pc_load_valid", 64'(pc_load_valid), 0);
    check("R10 enable_q", 64'(enable_q), 0);
    check("R10 cause_q", 64'(cause_q), 0);
  endtask

  task automatic t_enable_write();
    sw_write(1'b0, 10'h305);
    check("R11 enable_q", 64'(enable_q), 64'h05);
  endtask

  task automatic t_masked_event();
    evt_req = 8'h02; irq_en = 1;
    step();
    evt_req = '0;
    check("R1 no entry", 64'(debug_active), 0);
    check("R1 no cause", 64'(cause_q), 0);
  endtask

  task automatic t_single_entry_resume();
    cur_pc = 32'h0000_1000; cur_priv = 1;
    evt_req = 8'h01;
    step();
    evt_req = '0; cur_pc = 32'h0000_2222; cur_priv = 0;
    check("R2 entered", 64'(debug_active), 1);
    check("R2 cause", 64'(cause_q), 64'h001);
    check("R6 priv_user", 64'(priv_user), 0);
    check("R6 fetch_src_port", 64'(fetch_src_port), 1);
    check("R9 cause_any", 64'(cause_any), 1);
    evt_req = 8'h04;
    step();
    evt_req = '0;
    check("R9 live cause", 64'(cause_q), 64'h005);
    check("R9 still active", 64'(debug_active), 1);
    do_resume();
    check("R7 left debug", 64'(debug_active), 0);
    check("R7 fetch back", 64'(fetch_src_port), 0);
    check("R7 pc_load_valid", 64'(pc_load_valid), 1);
    check("R7 pc_load_addr", 64'(pc_load_addr), 64'h1000);
    check("R7 priv restored", 64'(priv_user), 1);
    step();
    check("R7 pulse one cycle", 64'(pc_load_valid), 0);
  endtask

  task automatic t_clear();
    sw_write(1'b1, 10'h001);
    check("R8 partial clear", 64'(cause_q), 64'h004);
    check("R9 any still 1", 64'(cause_any), 1);
    sw_write(1'b1, 10'h004);
    check("R8 full clear", 64'(cause_q), 0);
    check("R9 any 0", 64'(cause_any), 0);
  endtask

  task automatic t_set_wins_gated();
    irq_en = 0; evt_req = 8'h01;
    sw_write(1'b1, 10'h001);
    evt_req = '0;
    check("R8 set wins", 64'(cause_q), 64'h001);
    check("R4 gated no entry", 64'(debug_active), 0);
    irq_en = 1;
    sw_write(1'b1, 10'h001);
    check("R8 cleared", 64'(cause_q), 0);
  endtask

  task automatic t_simultaneous();
    cur_pc = 32'h0000_3000; cur_priv = 1;
    evt_req = 8'h05;
    step();
    evt_req = '0;
    check("R3 all causes", 64'(cause_q), 64'h005);
    check("R3 entered", 64'(debug_active), 1);
    do_resume();
    check("R3 single resume exits", 64'(debug_active), 0);
    check("R3 restart addr", 64'(pc_load_addr), 64'h3000);
    sw_write(1'b1, 10'h3FF);
  endtask

  task automatic t_force();
    irq_en = 0; cur_pc = 32'h0000_4000; cur_priv = 0;
    force_req = 1;
    step();
    force_req = 0;
    check("R4 forced entry", 64'(debug_active), 1);
    check("R4 force cause", 64'(cause_q), 64'(1) << FORCE_BIT);
    do_resume();
    check("R4 restart addr", 64'(pc_load_addr), 64'h4000);
    check("R7 supervisor restored", 64'(priv_user), 0);
    irq_en = 1;
  endtask

  task automatic t_boot_entry();
    do_reset(1'b1);
    cur_pc = 32'h0000_0100;
    step();
    reset_dbg_req = 0;
    check("R5 boot entry", 64'(debug_active), 1);
    check("R5 boot cause", 64'(cause_q), 64'(1) << BOOT_BIT);
    check("R5 enable cleared", 64'(enable_q), 0);
    do_resume();
    check("R5 restart addr", 64'(pc_load_addr), 64'h0100);
  endtask

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    t_reset_state();
    t_enable_write();
    t_masked_event();
    t_single_entry_resume();
    t_clear();
    t_set_wins_gated();
    t_simultaneous();
    t_force();
    t_boot_entry();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule